// File: doc/BRIEF.md
# Two-Wire Control Register Target for an Audio Processor

This block is the serial control front end of a programmable audio processor. It watches the two-wire bus (SCL and SDA), which it samples with a much faster system clock. It recognises START and STOP conditions and answers a single fixed 7-bit device address. In a write transfer, the first byte after the address is a subaddress. That byte carries a register index and a flag that turns auto-increment on or off. The data bytes that follow land in a bank of nine 8-bit control registers, and the analog processing blocks read those registers as parallel outputs.

In a read transfer the block does not return register contents. It returns a status byte built from two live mute-state inputs: soft mute active and zero-crossing mute active. The status is sampled again after every acknowledge, so a master can keep clocking out status bytes without addressing the device again. The block pulls SDA low through an open-drain style enable output. It never stretches the clock.

Top module: `actl_i2c_target`

## Requirements
- R1: After synchronous reset every control register holds 8'hFE and SDA is not pulled.
- R2: An address byte whose upper seven bits equal 7'b1000100 is acknowledged by holding SDA low for the whole ninth clock pulse; bit 0 of that byte selects write (0) or read (1).
- R3: An address byte that does not match gets no acknowledge, and all following bytes are ignored (no acknowledge, no register change) until the next START.
- R4: In a write, the byte after the address is a subaddress whose bits 3..0 give the register index and bit 4 the auto-increment enable; bits 7..5 have no effect, and each data byte is stored into the indexed register.
- R5: With auto-increment set, each further data byte of the same transfer goes to the next register index.
- R6: With auto-increment clear, every data byte of the transfer goes to the same register, so the last one is kept.
- R7: A data byte aimed at an index above 8 is acknowledged but not stored, and auto-increment does not advance past that point.
- R8: In a read, each returned byte is sent MSB first with bit 2 equal to the soft-mute input, bit 1 equal to the zero-crossing-mute input and all other bits 0.
- R9: After the master acknowledges a read byte, the next byte is built from freshly sampled status inputs; a master non-acknowledge ends the read and releases SDA.
- R10: A STOP returns the block to idle and drops a partly received byte unstored; a repeated START without STOP begins a new address phase.
- R11: The block changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| sm_state_i | input | 1 | Soft mute active status |
| zc_state_i | input | 1 | Zero-crossing mute active status |
| ctl_regs_o | output | 72 | Nine control registers, register n in bits 8n+7..8n |

## Verification
The embedded assertions check, on every cycle, that the SDA pull rises only while the synchronized SCL is low, and that a STOP always leaves SDA released and the engine idle. They also check that no write strobe ever targets an index beyond the bank, that the register bank holds its contents whenever no write strobe is present, and that the pointer stays frozen once it has run past the last register. Whole-transfer behaviour needs the bench scenarios: the mapping of subaddress fields to the register that actually changes, the auto-increment and fixed-index sequences, silence after a foreign address, and the resampling of the status byte between consecutive reads. The same holds for dropping a byte cut short by a STOP and for recovery through a repeated START.

// File: rtl/actl_i2c_pkg.sv
package actl_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } bus_st_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SUB,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/actl_line_sync.sv
module actl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // SDA edge while SCL stays high
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/actl_byte_engine.sv
module actl_byte_engine
  import actl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         NREG     = 9,
  parameter int         DW       = 8,
  parameter int         IDXW     = 4,
  parameter int         AINC_BIT = 4,
  parameter int         SM_BIT   = 2,
  parameter int         ZM_BIT   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_lvl,
  input  logic            sda_lvl,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            sm_i,
  input  logic            zm_i,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data
);
  localparam int PTRW = IDXW + 1;
  localparam int CNTW = $clog2(DW + 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DW);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(DW - 1);
  localparam logic [PTRW-1:0] PTR_END  = PTRW'(NREG);

  bus_st_e         st;
  byte_kind_e      kind;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   shift_q;
  logic [DW-1:0]   tx_sh;
  logic [PTRW-1:0] ptr;
  logic            ainc;
  logic            rw;
  logic            m_ack;
  logic [DW-1:0]   status_byte;

  always_comb begin
    status_byte         = '0;
    status_byte[SM_BIT] = sm_i;
    status_byte[ZM_BIT] = zm_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      kind    <= BK_ADDR;
      cnt     <= '0;
      shift_q <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      ainc    <= 1'b0;
      rw      <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        kind   <= BK_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != CNT_FULL) begin
              shift_q <= {shift_q[DW-2:0], sda_lvl};
              cnt     <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              case (kind)
                BK_ADDR: begin
                  if (shift_q[DW-1:1] == DEV_ADDR) begin
                    rw     <= shift_q[0];
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                    kind   <= BK_SUB;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                BK_SUB: begin
                  ptr    <= {1'b0, shift_q[IDXW-1:0]};
                  ainc   <= shift_q[AINC_BIT];
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  kind   <= BK_DATA;
                end
                default: begin
                  if (ptr < PTR_END) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr[IDXW-1:0];
                    wr_data <= shift_q;
                    if (ainc) ptr <= ptr + 1'b1;
                  end
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx_sh  <= status_byte;
                sda_oe <= ~status_byte[DW-1];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                sda_oe <= 1'b0;
                m_ack  <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh  <= status_byte;
                sda_oe <= ~status_byte[DW-1];
                cnt    <= '0;
                st     <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a new pull on SDA only appears while SCL is low
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R10: STOP leaves the bus released and the engine idle
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && st == ST_IDLE));

  // R7: once past the last register the pointer no longer moves
  assert_ptr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (kind == BK_DATA && ptr >= PTR_END) |=> (ptr == $past(ptr)));

  // R3: a foreign address leaves SDA released
  assert_foreign_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX && kind == BK_ADDR && scl_fall && cnt == CNT_FULL
     && !start_det && !stop_det && shift_q[DW-1:1] != DEV_ADDR)
    |=> (st == ST_IDLE && !sda_oe));
endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank #(
  parameter int          NREG    = 9,
  parameter int          DW      = 8,
  parameter int          IDXW    = 4,
  parameter logic [7:0]  RST_VAL = 8'hFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_o
);
  logic rst_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= DW'(RST_VAL);
      else if (wr_en && wr_idx == IDXW'(g)) q <= wr_data;
    end
    assign regs_o[g*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1: reset leaves every register at the power-on pattern
    if (rst_q && !rst) begin
      assert_reset_val_R1: assert (regs_o == {NREG{DW'(RST_VAL)}});
    end
  end

  // R7: the engine never strobes an index outside the bank
  assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_idx) < NREG));

  // R4: contents move only on a write strobe
  assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (regs_o == $past(regs_o)));
endmodule

// File: rtl/actl_i2c_target.sv
module actl_i2c_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         NREG        = 9,
  parameter int         DW          = 8,
  parameter int         IDXW        = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RST_VAL     = 8'hFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               sm_state_i,
  input  logic               zc_state_i,
  output logic [NREG*DW-1:0] ctl_regs_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [DW-1:0]   wr_data;

  actl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  actl_byte_engine #(
    .DEV_ADDR (DEV_ADDR),
    .NREG     (NREG),
    .DW       (DW),
    .IDXW     (IDXW)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sm_i      (sm_state_i),
    .zm_i      (zc_state_i),
    .sda_oe    (sda_pull_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  actl_reg_bank #(
    .NREG    (NREG),
    .DW      (DW),
    .IDXW    (IDXW),
    .RST_VAL (RST_VAL)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_o  (ctl_regs_o)
  );
endmodule

// File: tb/actl_i2c_target_tb.sv
module actl_i2c_target_tb;
  localparam int NREG = 9;
  localparam int Q    = 8;

  typedef struct {
    string      tag;
    logic [7:0] val;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sm_st = 1'b0;
  logic zc_st = 1'b0;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  item_t      exp_q[$];
  logic [7:0] obs_q[$];
  logic [7:0] model[NREG];

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  actl_i2c_target u_dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .sm_state_i (sm_st),
    .zc_state_i (zc_st),
    .ctl_regs_o (regs)
  );

  // monitor: pairs observed results with expected items
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t      e;
        logic [7:0] a;
        e = exp_q.pop_front();
        a = obs_q.pop_front();
        checks++;
        if (a !== e.val) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;  wait_clk(Q);
    m_scl = 1'b1; wait_clk(2 * Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag, input logic exp_nack);
    logic got;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    got = sda_line; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
    exp_q.push_back('{tag, {7'b0, exp_nack}});
    obs_q.push_back({7'b0, got});
  endtask

  task automatic read_byte(input logic [7:0] expv, input string tag);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_clk(Q);
      m_scl = 1'b1; wait_clk(Q);
      v[i] = sda_line; wait_clk(Q);
      m_scl = 1'b0; wait_clk(Q);
    end
    exp_q.push_back('{tag, expv});
    obs_q.push_back(v);
  endtask

  task automatic check_regs(input string tag);
    wait_clk(4);
    for (int g = 0; g < NREG; g++) begin
      exp_q.push_back('{tag, model[g]});
      obs_q.push_back(regs[g*8 +: 8]);
    end
  endtask

  initial begin
    for (int g = 0; g < NREG; g++) model[g] = 8'hFE;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1: reset state
    check_regs("R1 reset");
    exp_q.push_back('{"R1 pull", 8'h00});
    obs_q.push_back({7'b0, sda_pull});

    // R2 R4 R5: auto-increment write from index 2
    bus_start();
    send_byte(8'h88, "R2 addr ack", 1'b0);
    send_byte(8'h12, "R4 sub ack", 1'b0);
    send_byte(8'h11, "R5 data ack", 1'b0);
    send_byte(8'h22, "R5 data ack", 1'b0);
    send_byte(8'h33, "R5 data ack", 1'b0);
    bus_stop();
    model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
    check_regs("R5 autoinc");

    // R6 R4: fixed index 5, upper subaddress bits set
    bus_start();
    send_byte(8'h88, "R2 addr ack", 1'b0);
    send_byte(8'hE5, "R4 sub ack", 1'b0);
    send_byte(8'hA1, "R6 data ack", 1'b0);
    send_byte(8'hA2, "R6 data ack", 1'b0);
    bus_stop();
    model[5] = 8'hA2;
    check_regs("R6 fixed index");

    // R7: run past the last register, then address index 12
    bus_start();
    send_byte(8'h88, "R2 addr ack", 1'b0);
    send_byte(8'h17, "R4 sub ack", 1'b0);
    send_byte(8'h01, "R5 data ack", 1'b0);
    send_byte(8'h02, "R5 data ack", 1'b0);
    send_byte(8'h03, "R7 overflow ack", 1'b0);
    send_byte(8'h04, "R7 overflow ack", 1'b0);
    bus_stop();
    model[7] = 8'h01; model[8] = 8'h02;
    check_regs("R7 overflow dropped");
    bus_start();
    send_byte(8'h88, "R2 addr ack", 1'b0);
    send_byte(8'h1C, "R4 sub ack", 1'b0);
    send_byte(8'h55, "R7 high index ack", 1'b0);
    bus_stop();
    check_regs("R7 high index dropped");

    // R3: foreign address
    bus_start();
    send_byte(8'h8A, "R3 foreign nack", 1'b1);
    send_byte(8'h00, "R3 ignored nack", 1'b1);
    send_byte(8'h99, "R3 ignored nack", 1'b1);
    bus_stop();
    check_regs("R3 unchanged");

    // R8 R9: status reads with resampling
    sm_st = 1'b1; zc_st = 1'b0;
    bus_start();
    send_byte(8'h89, "R2 read addr ack", 1'b0);
    read_byte(8'h04, "R8 soft mute bit");
    sm_st = 1'b0; zc_st = 1'b1;
    put_bit(1'b0);
    read_byte(8'h02, "R9 resampled");
    sm_st = 1'b1; zc_st = 1'b1;
    put_bit(1'b0);
    read_byte(8'h06, "R9 both bits");
    put_bit(1'b1);
    wait_clk(2);
    exp_q.push_back('{"R9 released after nack", 8'h00});
    obs_q.push_back({7'b0, sda_pull});
    bus_stop();

    // R10: STOP in mid byte drops it
    bus_start();
    send_byte(8'h88, "R2 addr ack", 1'b0);
    send_byte(8'h10, "R4 sub ack", 1'b0);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check_regs("R10 partial dropped");

    // R10: repeated START into a read
    bus_start();
    send_byte(8'h88, "R2 addr ack", 1'b0);
    send_byte(8'h01, "R4 sub ack", 1'b0);
    send_byte(8'h5A, "R4 data ack", 1'b0);
    sm_st = 1'b0; zc_st = 1'b0;
    bus_start();
    send_byte(8'h89, "R10 restart ack", 1'b0);
    read_byte(8'h00, "R8 idle status");
    put_bit(1'b1);
    bus_stop();
    model[1] = 8'h5A;
    check_regs("R10 restart write");

    // R11 spot check: SDA idle while bus idle
    wait_clk(4);
    exp_q.push_back('{"R11 idle release", 8'h00});
    obs_q.push_back({7'b0, sda_pull});

    wait_clk(4);
    while (obs_q.size() > 0) wait_clk(1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule